// File: doc/BRIEF.md
# Scroll Address Updater

This block holds the 15-bit video memory address used by a tile-based renderer while it draws a frame, together with a 15-bit staging register that is loaded from outside. During rendering it advances the address in step with the scanline and dot counters. It steps the horizontal tile column after each tile fetch and the pixel row once per line. At the end of each line it restores the horizontal scroll position from the staging register. On the pre-render line it restores the vertical scroll position.

The address is split into fields. Bits 4:0 hold the tile column (coarse X) and bits 9:5 hold the tile row (coarse Y). Bit 10 selects the horizontal name table and bit 11 the vertical one. Bits 14:12 hold the pixel row inside the tile (fine Y). The horizontal group is bits 10 and 4:0. The vertical group is bits 14:11 and 9:5.

The scanline and dot counters, the rendering-enabled flag and the staging-register load come in from the surrounding logic. Every update is registered, so an update selected by the counters in one cycle shows on the output after the next rising clock edge.

Top module: `scroll_addr_unit`

## Requirements
- R1: After a synchronous active-high reset, `v_addr` is 0 and the staging register is 0.
- R2: The field layout of `v_addr` is: coarse X in bits 4:0, coarse Y in bits 9:5, horizontal name-table select in bit 10, vertical name-table select in bit 11, and fine Y in bits 14:12.
- R3: On render lines (scanlines 0 to 239 and scanline 261), coarse X increments at dots 8, 16 and every eighth dot up to 256, and at dots 328 and 336. When coarse X is 31, it wraps to 0 and bit 10 is inverted.
- R4: On render lines at dot 256, fine Y increments. When fine Y is 7, it wraps to 0 and coarse Y advances.
- R5: When coarse Y advances from 29, it becomes 0 and bit 11 is inverted.
- R6: When coarse Y advances from 31, it becomes 0 and bit 11 is unchanged. From any other value it simply increments, so 30 becomes 31.
- R7: On render lines at dot 257, bits 10 and 4:0 of `v_addr` are loaded from the staging register. The other bits are kept.
- R8: On scanline 261 at every dot from 280 through 304, bits 14:11 and 9:5 are loaded from the staging register. The other bits are kept.
- R9: While `render_en` is low, `v_addr` does not change.
- R10: A cycle with `t_load` high writes all 15 bits of `t_data` into the staging register. This write has no direct effect on `v_addr`.
- R11: At any scanline or dot position not listed in R3, R4, R7 or R8 (for example dot 12, dot 305, or scanline 240), `v_addr` does not change. Each update appears on `v_addr` one clock edge after the inputs that select it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| render_en | input | 1 | Rendering enabled; gates every update of the address |
| scanline | input | 9 | Current scanline number |
| dot | input | 9 | Current dot within the scanline |
| t_load | input | 1 | Write strobe for the staging register |
| t_data | input | 15 | Value written into the staging register |
| v_addr | output | 15 | Current video memory address (registered) |

## Verification
Every update (increment, wrap, horizontal copy, vertical copy) is due exactly one rising edge after the counter values that select it are presented. The bench drives the counters just after a falling edge and reads `v_addr` at the following falling edge, so each check looks at the result of one position only. The staging register is only visible through the copies. A staging-register write therefore becomes observable no earlier than one edge after a later copy position, and the bench inspects `v_addr` between the write and that copy to show that the write alone changed nothing.

// File: rtl/scroll_pkg.sv
package scroll_pkg;

  localparam int VADDR_W = 15;

  typedef struct packed {
    logic [2:0] fine_y;
    logic       nt_y;
    logic       nt_x;
    logic [4:0] coarse_y;
    logic [4:0] coarse_x;
  } vaddr_t;

  localparam logic [VADDR_W-1:0] HORIZ_MASK = 15'h041F;
  localparam logic [VADDR_W-1:0] VERT_MASK  = 15'h7BE0;

endpackage

// File: rtl/scroll_dot_decode.sv
module scroll_dot_decode #(
  parameter int CNT_W        = 9,
  parameter int VIS_LINES    = 240,
  parameter int PRE_LINE     = 261,
  parameter int TILE_DOTS    = 8,
  parameter int FETCH_LAST   = 256,
  parameter int PREF_FIRST   = 328,
  parameter int PREF_LAST    = 336,
  parameter int Y_INC_DOT    = 256,
  parameter int H_COPY_DOT   = 257,
  parameter int V_COPY_FIRST = 280,
  parameter int V_COPY_LAST  = 304
) (
  input  logic             render_en,
  input  logic [CNT_W-1:0] scanline,
  input  logic [CNT_W-1:0] dot,
  output logic             x_inc,
  output logic             y_inc,
  output logic             h_copy,
  output logic             v_copy
);

  localparam logic [CNT_W-1:0] TILE_MASK = CNT_W'(TILE_DOTS - 1);

  logic render_line;
  logic pre_line;
  logic tile_edge;
  logic in_fetch;

  always_comb begin
    pre_line    = (scanline == CNT_W'(PRE_LINE));
    render_line = (scanline < CNT_W'(VIS_LINES)) || pre_line;
    tile_edge   = ((dot & TILE_MASK) == '0) && (dot != '0);
    in_fetch    = (dot <= CNT_W'(FETCH_LAST)) ||
                  ((dot >= CNT_W'(PREF_FIRST)) && (dot <= CNT_W'(PREF_LAST)));
    x_inc  = render_en && render_line && tile_edge && in_fetch;
    y_inc  = render_en && render_line && (dot == CNT_W'(Y_INC_DOT));
    h_copy = render_en && render_line && (dot == CNT_W'(H_COPY_DOT));
    v_copy = render_en && pre_line &&
             (dot >= CNT_W'(V_COPY_FIRST)) && (dot <= CNT_W'(V_COPY_LAST));
  end

endmodule

// File: rtl/scroll_t_reg.sv
module scroll_t_reg
  import scroll_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               t_load,
  input  logic [VADDR_W-1:0] t_data,
  output logic [VADDR_W-1:0] t_q
);

  always_ff @(posedge clk) begin
    if (rst)         t_q <= '0;
    else if (t_load) t_q <= t_data;
  end

  // R10: staging value only changes on a load
  a_r10_t_hold: assert property (@(posedge clk) disable iff (rst)
    !t_load |=> $stable(t_q));

  a_r10_t_write: assert property (@(posedge clk) disable iff (rst)
    t_load |=> (t_q == $past(t_data)));

endmodule

// File: rtl/scroll_v_reg.sv
module scroll_v_reg
  import scroll_pkg::*;
#(
  parameter int LAST_ROW = 29
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               x_inc,
  input  logic               y_inc,
  input  logic               h_copy,
  input  logic               v_copy,
  input  logic [VADDR_W-1:0] t_q,
  output vaddr_t             v_q
);

  localparam logic [4:0] ROW_END = 5'(LAST_ROW);
  localparam logic [4:0] ROW_MAX = 5'd31;
  localparam logic [2:0] FY_MAX  = 3'd7;

  vaddr_t nxt;
  vaddr_t stepped;

  always_comb begin
    stepped = v_q;
    if (x_inc) begin
      if (v_q.coarse_x == ROW_MAX) begin
        stepped.coarse_x = '0;
        stepped.nt_x     = ~v_q.nt_x;
      end else begin
        stepped.coarse_x = v_q.coarse_x + 5'd1;
      end
    end
    if (y_inc) begin
      if (v_q.fine_y != FY_MAX) begin
        stepped.fine_y = v_q.fine_y + 3'd1;
      end else begin
        stepped.fine_y = '0;
        if (v_q.coarse_y == ROW_END) begin
          stepped.coarse_y = '0;
          stepped.nt_y     = ~v_q.nt_y;
        end else if (v_q.coarse_y == ROW_MAX) begin
          stepped.coarse_y = '0;
        end else begin
          stepped.coarse_y = v_q.coarse_y + 5'd1;
        end
      end
    end
    nxt = stepped;
    if (h_copy) nxt = vaddr_t'((nxt & ~HORIZ_MASK) | (t_q & HORIZ_MASK));
    if (v_copy) nxt = vaddr_t'((nxt & ~VERT_MASK) | (t_q & VERT_MASK));
  end

  always_ff @(posedge clk) begin
    if (rst) v_q <= '0;
    else     v_q <= nxt;
  end

  // R11: no selected update, no change
  a_r11_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !(x_inc || y_inc || h_copy || v_copy) |=> $stable(v_q));

  // R7: horizontal group follows staging register
  a_r7_hcopy: assert property (@(posedge clk) disable iff (rst)
    h_copy |=> (((v_q ^ $past(t_q)) & HORIZ_MASK) == '0));

  // R8: vertical group follows staging register
  a_r8_vcopy: assert property (@(posedge clk) disable iff (rst)
    v_copy |=> (((v_q ^ $past(t_q)) & VERT_MASK) == '0));

  // R3: column wrap flips horizontal table select
  a_r3_x_wrap: assert property (@(posedge clk) disable iff (rst)
    (x_inc && !h_copy && v_q.coarse_x == ROW_MAX)
      |=> (v_q.coarse_x == '0) && (v_q.nt_x != $past(v_q.nt_x)));

  // R5: last visible row wraps and flips vertical table select
  a_r5_row_wrap: assert property (@(posedge clk) disable iff (rst)
    (y_inc && !v_copy && v_q.fine_y == FY_MAX && v_q.coarse_y == ROW_END)
      |=> (v_q.coarse_y == '0) && (v_q.nt_y != $past(v_q.nt_y)));

  // R6: row 31 wraps without flipping
  a_r6_row_max: assert property (@(posedge clk) disable iff (rst)
    (y_inc && !v_copy && v_q.fine_y == FY_MAX && v_q.coarse_y == ROW_MAX)
      |=> (v_q.coarse_y == '0) && $stable(v_q.nt_y));

endmodule

// File: rtl/scroll_addr_unit.sv
module scroll_addr_unit
  import scroll_pkg::*;
#(
  parameter int CNT_W        = 9,
  parameter int VIS_LINES    = 240,
  parameter int PRE_LINE     = 261,
  parameter int TILE_DOTS    = 8,
  parameter int FETCH_LAST   = 256,
  parameter int PREF_FIRST   = 328,
  parameter int PREF_LAST    = 336,
  parameter int Y_INC_DOT    = 256,
  parameter int H_COPY_DOT   = 257,
  parameter int V_COPY_FIRST = 280,
  parameter int V_COPY_LAST  = 304,
  parameter int LAST_ROW     = 29
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               render_en,
  input  logic [CNT_W-1:0]   scanline,
  input  logic [CNT_W-1:0]   dot,
  input  logic               t_load,
  input  logic [VADDR_W-1:0] t_data,
  output logic [VADDR_W-1:0] v_addr
);

  logic x_inc, y_inc, h_copy, v_copy;
  logic [VADDR_W-1:0] t_q;
  vaddr_t v_q;

  scroll_dot_decode #(
    .CNT_W(CNT_W), .VIS_LINES(VIS_LINES), .PRE_LINE(PRE_LINE),
    .TILE_DOTS(TILE_DOTS), .FETCH_LAST(FETCH_LAST),
    .PREF_FIRST(PREF_FIRST), .PREF_LAST(PREF_LAST),
    .Y_INC_DOT(Y_INC_DOT), .H_COPY_DOT(H_COPY_DOT),
    .V_COPY_FIRST(V_COPY_FIRST), .V_COPY_LAST(V_COPY_LAST)
  ) u_decode (
    .render_en(render_en), .scanline(scanline), .dot(dot),
    .x_inc(x_inc), .y_inc(y_inc), .h_copy(h_copy), .v_copy(v_copy)
  );

  scroll_t_reg u_treg (
    .clk(clk), .rst(rst), .t_load(t_load), .t_data(t_data), .t_q(t_q)
  );

  scroll_v_reg #(.LAST_ROW(LAST_ROW)) u_vreg (
    .clk(clk), .rst(rst), .x_inc(x_inc), .y_inc(y_inc),
    .h_copy(h_copy), .v_copy(v_copy), .t_q(t_q), .v_q(v_q)
  );

  assign v_addr = v_q;

  // R9: rendering disabled freezes the address
  a_r9_render_off: assert property (@(posedge clk) disable iff (rst)
    !render_en |=> $stable(v_addr));

  // R1: reset clears the address
  a_r1_reset: assert property (@(posedge clk)
    rst |=> (v_addr == '0));

endmodule

// File: tb/test_scroll_addr_unit.sv
module test_scroll_addr_unit;

  logic        clk = 1'b0;
  logic        rst;
  logic        render_en;
  logic [8:0]  scanline;
  logic [8:0]  dot;
  logic        t_load;
  logic [14:0] t_data;
  logic [14:0] v_addr;

  int n_tests = 0;
  int n_fail  = 0;

  always #2 clk = ~clk;

  scroll_addr_unit i_scroll_addr_unit (
    .clk(clk), .rst(rst), .render_en(render_en), .scanline(scanline),
    .dot(dot), .t_load(t_load), .t_data(t_data), .v_addr(v_addr)
  );

  task automatic chk(input string req, input logic [14:0] exp);
    n_tests++;
    if (v_addr !== exp) begin
      n_fail++;
      $display("FAIL %s: v_addr actual=%h expected=%h", req, v_addr, exp);
    end
  endtask

  // entered at a falling edge; result readable at return
  task automatic step(input int sl, input int dt, input logic en);
    scanline  = 9'(sl);
    dot       = 9'(dt);
    render_en = en;
    @(negedge clk);
  endtask

  task automatic load_t(input logic [14:0] val);
    t_load = 1'b1;
    t_data = val;
    step(250, 0, 1'b1);
    t_load = 1'b0;
  endtask

  task automatic set_v(input logic [14:0] val);
    load_t(val);
    step(261, 280, 1'b1);
    step(0, 257, 1'b1);
  endtask

  task automatic t_reset;
    chk("R1 reset value", 15'h0000);
  endtask

  task automatic t_load_only;
    load_t(15'h7FFF);
    chk("R10 staging write leaves v", 15'h0000);
    step(100, 3, 1'b1);
    chk("R10 v still clear", 15'h0000);
  endtask

  task automatic t_copies;
    step(0, 257, 1'b1);
    chk("R7 horizontal copy", 15'h041F);
    step(261, 280, 1'b1);
    chk("R8 vertical copy first dot", 15'h7FFF);
    load_t(15'h0000);
    step(261, 304, 1'b1);
    chk("R8 vertical copy last dot", 15'h041F);
    load_t(15'h7BE0);
    step(261, 305, 1'b1);
    chk("R11 dot 305 no copy", 15'h041F);
    step(261, 279, 1'b1);
    chk("R11 dot 279 no copy", 15'h041F);
    step(10, 257, 1'b1);
    chk("R7 copy keeps vertical bits", 15'h0000);
  endtask

  task automatic t_coarse_x;
    set_v(15'h001E);
    chk("R2 set coarse X 30", 15'h001E);
    step(0, 8, 1'b1);
    chk("R3 coarse X step", 15'h001F);
    step(0, 16, 1'b1);
    chk("R3 coarse X wrap flips bit 10", 15'h0400);
    step(0, 12, 1'b1);
    chk("R11 dot 12 no step", 15'h0400);
    step(0, 328, 1'b1);
    chk("R3 prefetch dot 328", 15'h0401);
    step(240, 8, 1'b1);
    chk("R11 line 240 no step", 15'h0401);
    step(261, 336, 1'b1);
    chk("R3 prefetch dot 336 on line 261", 15'h0402);
    step(0, 344, 1'b1);
    chk("R11 dot 344 no step", 15'h0402);
  endtask

  task automatic t_fine_y;
    set_v(15'h3000);
    step(0, 256, 1'b1);
    chk("R4 fine Y step with coarse X", 15'h4001);
    set_v(15'h70A0);
    step(5, 256, 1'b1);
    chk("R4 fine Y carry into coarse Y", 15'h00C1);
  endtask

  task automatic t_row_wrap;
    set_v(15'h73A0);
    step(0, 256, 1'b1);
    chk("R5 row 29 wraps, bit 11 set", 15'h0801);
    set_v(15'h7BA0);
    step(0, 256, 1'b1);
    chk("R5 row 29 wraps, bit 11 cleared", 15'h0001);
  endtask

  task automatic t_row_max;
    set_v(15'h73C0);
    step(0, 256, 1'b1);
    chk("R6 row 30 to 31", 15'h03E1);
    set_v(15'h73E0);
    step(0, 256, 1'b1);
    chk("R6 row 31 wraps without flip", 15'h0001);
  endtask

  task automatic t_render_off;
    set_v(15'h2A5F);
    load_t(15'h0000);
    step(0, 256, 1'b0);
    chk("R9 no increment when disabled", 15'h2A5F);
    step(0, 257, 1'b0);
    chk("R9 no horizontal copy when disabled", 15'h2A5F);
    step(261, 290, 1'b0);
    chk("R9 no vertical copy when disabled", 15'h2A5F);
  endtask

  initial begin
    rst = 1'b1; render_en = 1'b0; scanline = '0; dot = '0;
    t_load = 1'b0; t_data = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_load_only();
    t_copies();
    t_coarse_x();
    t_fine_y();
    t_row_wrap();
    t_row_max();
    t_render_off();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule